// File: doc/BRIEF.md
# Time base and decrementer

This block keeps three counters for a processor core. Two are 64-bit up-counters, a main time base and an alternate time base. The third is a 32-bit decrementer that counts down and flags an interrupt when it runs out. Both time bases step on a shared tick strobe and stop while a run input is low. The decrementer has its own tick strobe and keeps running while the time bases are stopped.

Software reaches the counters through a small command port. Each command names one 32-bit view: a half of a time base, the decrementer, or a masked view of the main time base's lower half that older code expects. The command side uses a valid/ready handshake. `cmd_ready` is always high, so a command is accepted in every cycle in which `cmd_valid` is high and there is never back-pressure. The read response is a plain strobe, `rd_valid`, that comes one cycle after the read was accepted and cannot be stalled. The consumer must take the response in that cycle.

The decrementer interrupt is a sticky flag. It stays high until the core pulses the acknowledge input.

Top module: `timebase_dec`

## Requirements
- R1: When `tb_run` and `tb_tick` are both high and no command writes the main time base, the main time base increases by exactly one, and a carry out of the lower half goes into the upper half.
- R2: While `tb_run` is low, both time bases hold their value even if `tb_tick` pulses. When `tb_run` goes high again, counting resumes from the held value.
- R3: Writing the lower half of a time base (code 0 or 2) leaves its upper half unchanged. Writing the upper half (code 1 or 3) leaves its lower half unchanged.
- R4: The alternate time base is written through its own codes (2 and 3). It steps under the same tick and run conditions as the main time base, and writing one time base never changes the other.
- R5: The decrementer decreases by one on each cycle in which `dec_tick` is high, whatever the value of `tb_run`.
- R6: A `dec_tick` while the decrementer holds zero loads 0xFFFFFFFF and sets `dec_irq` on the next cycle. Counting then continues downward from that value.
- R7: A write to the decrementer (code 4) with bit 31 set, made while the current value has bit 31 clear, sets `dec_irq` on the next cycle. A write that does not meet this condition does not set the flag.
- R8: After reset both time bases read zero, the decrementer reads 0xFFFFFFFF, and `dec_irq` and `rd_valid` are low.
- R9: Code 5 reads the main time base's lower half ANDed with 0x3FFFFF80. A write through code 5 replaces only the bits inside that mask. All other bits of the lower half, and all of the upper half, keep their value.
- R10: A write to a counter in the same cycle as that counter's tick takes the written value, with no step applied in that cycle.
- R11: `dec_irq` stays high until a cycle in which `dec_irq_ack` is high and no new interrupt event occurs; it then clears. An event in the same cycle as the acknowledge keeps the flag high.
- R12: `cmd_ready` is always high. An accepted read (`cmd_write` low) gives `rd_valid` high in the next cycle, with `rd_data` holding the addressed view's value from the request cycle. Codes 6 and 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | Step strobe for both time bases |
| tb_run | input | 1 | Run enable for both time bases; low freezes them |
| dec_tick | input | 1 | Step strobe for the decrementer |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted; always high |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 3 | View code: 0/1 main low/high, 2/3 alternate low/high, 4 decrementer, 5 masked main low |
| cmd_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response strobe, one cycle after the read |
| rd_data | output | 32 | Read response data |
| dec_irq | output | 1 | Sticky decrementer interrupt |
| dec_irq_ack | input | 1 | Clears `dec_irq` |

## Verification
The assertions assume that a write to the decrementer is the only way bit 31 can go from clear to set outside an expiry. They also assume that the strobes are sampled as clean single-cycle levels, with no relation required between `tb_tick`, `dec_tick` and commands, so every combination of the three may happen in one cycle. The stimulus drives every input one time unit after the rising edge and holds it until the next edge. It mixes directed sequences (carry across halves, wrap through zero, negative loads over both signs, acknowledge colliding with an event) with a long stretch of random commands, strobes and acknowledges over all eight codes. A cycle-level reference model checks each read response and the interrupt flag.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  localparam int SEL_W = 3;

  // View codes decoded by the command port.
  typedef enum logic [SEL_W-1:0] {
    SEL_TB_LO     = 3'd0,
    SEL_TB_HI     = 3'd1,
    SEL_ATB_LO    = 3'd2,
    SEL_ATB_HI    = 3'd3,
    SEL_DEC       = 3'd4,
    SEL_TB_COMPAT = 3'd5
  } sel_e;

  // Per-half write strobes for a split 64-bit counter.
  typedef struct packed {
    logic lo;
    logic hi;
  } half_wr_t;
endpackage

// File: rtl/tbd_split_counter.sv
module tbd_split_counter #(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  count_en,
  input  tbd_pkg::half_wr_t     wr,
  input  logic [HALF_W-1:0]     lo_mask,
  input  logic [HALF_W-1:0]     wdata,
  output logic [2*HALF_W-1:0]   value
);
  localparam int FULL_W = 2 * HALF_W;

  logic [HALF_W-1:0] lo_q, hi_q;
  logic [FULL_W-1:0] stepped;

  assign stepped = {hi_q, lo_q} + FULL_W'(1);
  assign value   = {hi_q, lo_q};

  // A write to either half blocks the step for that cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr.lo || wr.hi) begin
      if (wr.lo) lo_q <= (lo_q & ~lo_mask) | (wdata & lo_mask);
      if (wr.hi) hi_q <= wdata;
    end else if (count_en) begin
      {hi_q, lo_q} <= stepped;
    end
  end
endmodule

// File: rtl/tbd_decrementer.sv
module tbd_decrementer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         ack,
  output logic [W-1:0] value,
  output logic         irq
);
  logic [W-1:0] cnt_q;
  logic         irq_q;
  logic         expire, neg_load, raise;

  assign expire   = tick && !wr && (cnt_q == '0);
  assign neg_load = wr && wdata[W-1] && !cnt_q[W-1];
  assign raise    = expire || neg_load;

  // Stepping down from zero lands on all ones, which is the reload value.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '1;
      irq_q <= 1'b0;
    end else begin
      if (wr)        cnt_q <= wdata;
      else if (tick) cnt_q <= cnt_q - W'(1);
      if (raise)     irq_q <= 1'b1;
      else if (ack)  irq_q <= 1'b0;
    end
  end

  assign value = cnt_q;
  assign irq   = irq_q;
endmodule

// File: rtl/tbd_regport.sv
module tbd_regport #(
  parameter int                HALF_W      = 32,
  parameter logic [HALF_W-1:0] COMPAT_MASK = 32'h3FFF_FF80
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic                        cmd_write,
  input  logic [tbd_pkg::SEL_W-1:0]   cmd_addr,
  input  logic [HALF_W-1:0]           cmd_wdata,
  input  logic [2*HALF_W-1:0]         tb_val,
  input  logic [2*HALF_W-1:0]         atb_val,
  input  logic [HALF_W-1:0]           dec_val,
  output tbd_pkg::half_wr_t           tb_wr,
  output tbd_pkg::half_wr_t           atb_wr,
  output logic [HALF_W-1:0]           tb_lo_mask,
  output logic                        dec_wr,
  output logic                        rd_valid,
  output logic [HALF_W-1:0]           rd_data
);
  import tbd_pkg::*;

  sel_e              sel;
  logic              wr_go, rd_go;
  logic [HALF_W-1:0] rd_next;
  logic              rd_valid_q;
  logic [HALF_W-1:0] rd_data_q;

  assign sel   = sel_e'(cmd_addr);
  assign wr_go = cmd_valid && cmd_write;
  assign rd_go = cmd_valid && !cmd_write;

  always_comb begin
    tb_wr      = '0;
    atb_wr     = '0;
    dec_wr     = 1'b0;
    tb_lo_mask = '1;
    rd_next    = '0;
    case (sel)
      SEL_TB_LO: begin
        tb_wr.lo = wr_go;
        rd_next  = tb_val[HALF_W-1:0];
      end
      SEL_TB_HI: begin
        tb_wr.hi = wr_go;
        rd_next  = tb_val[2*HALF_W-1:HALF_W];
      end
      SEL_ATB_LO: begin
        atb_wr.lo = wr_go;
        rd_next   = atb_val[HALF_W-1:0];
      end
      SEL_ATB_HI: begin
        atb_wr.hi = wr_go;
        rd_next   = atb_val[2*HALF_W-1:HALF_W];
      end
      SEL_DEC: begin
        dec_wr  = wr_go;
        rd_next = dec_val;
      end
      SEL_TB_COMPAT: begin
        tb_wr.lo   = wr_go;
        tb_lo_mask = COMPAT_MASK;
        rd_next    = tb_val[HALF_W-1:0] & COMPAT_MASK;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_go;
      if (rd_go) rd_data_q <= rd_next;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/timebase_dec.sv
module timebase_dec #(
  parameter int          HALF_W      = 32,
  parameter logic [31:0] COMPAT_MASK = 32'h3FFF_FF80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_tick,
  input  logic              tb_run,
  input  logic              dec_tick,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [2:0]        cmd_addr,
  input  logic [HALF_W-1:0] cmd_wdata,
  output logic              rd_valid,
  output logic [HALF_W-1:0] rd_data,
  output logic              dec_irq,
  input  logic              dec_irq_ack
);
  import tbd_pkg::*;

  localparam int NUM_TB = 2;
  localparam int FULL_W = 2 * HALF_W;

  half_wr_t          tb_wr, atb_wr;
  logic [HALF_W-1:0] tb_lo_mask;
  logic              dec_wr;
  logic [FULL_W-1:0] tb_val, atb_val;
  logic [HALF_W-1:0] dec_val;
  logic              base_step;

  half_wr_t          wr_v   [NUM_TB];
  logic [HALF_W-1:0] mask_v [NUM_TB];
  logic [FULL_W-1:0] val_v  [NUM_TB];

  assign cmd_ready = 1'b1;
  assign base_step = tb_tick && tb_run;

  tbd_regport #(.HALF_W(HALF_W), .COMPAT_MASK(COMPAT_MASK[HALF_W-1:0])) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_write  (cmd_write),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .tb_val     (tb_val),
    .atb_val    (atb_val),
    .dec_val    (dec_val),
    .tb_wr      (tb_wr),
    .atb_wr     (atb_wr),
    .tb_lo_mask (tb_lo_mask),
    .dec_wr     (dec_wr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  assign wr_v[0]   = tb_wr;
  assign wr_v[1]   = atb_wr;
  assign mask_v[0] = tb_lo_mask;
  assign mask_v[1] = '1;

  for (genvar g = 0; g < NUM_TB; g++) begin : g_base
    tbd_split_counter #(.HALF_W(HALF_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_en (base_step),
      .wr       (wr_v[g]),
      .lo_mask  (mask_v[g]),
      .wdata    (cmd_wdata),
      .value    (val_v[g])
    );
  end

  assign tb_val  = val_v[0];
  assign atb_val = val_v[1];

  tbd_decrementer #(.W(HALF_W)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (dec_tick),
    .wr    (dec_wr),
    .wdata (cmd_wdata),
    .ack   (dec_irq_ack),
    .value (dec_val),
    .irq   (dec_irq)
  );
endmodule

// File: rtl/timebase_dec_chk.sv
module timebase_dec_chk #(
  parameter int HALF_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tb_tick,
  input logic                tb_run,
  input logic                dec_tick,
  input logic                cmd_valid,
  input logic                cmd_write,
  input logic [2:0]          cmd_addr,
  input logic                wdata_msb,
  input logic                rd_valid,
  input logic                dec_irq,
  input logic                dec_irq_ack,
  input logic [2*HALF_W-1:0] tb_val,
  input logic [2*HALF_W-1:0] atb_val,
  input logic [HALF_W-1:0]   dec_val
);
  localparam int FULL_W = 2 * HALF_W;

  logic wr_go, wr_tb, wr_atb, wr_dec;
  assign wr_go  = cmd_valid && cmd_write;
  assign wr_tb  = wr_go && (cmd_addr == 3'd0 || cmd_addr == 3'd1 || cmd_addr == 3'd5);
  assign wr_atb = wr_go && (cmd_addr == 3'd2 || cmd_addr == 3'd3);
  assign wr_dec = wr_go && (cmd_addr == 3'd4);

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_run && tb_tick && !wr_tb) |=> (tb_val == $past(tb_val) + FULL_W'(1)));

  p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_run && !wr_tb && !wr_atb) |=> ($stable(tb_val) && $stable(atb_val)));

  p_alt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_run && tb_tick && !wr_atb) |=> (atb_val == $past(atb_val) + FULL_W'(1)));

  p_dec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_tick && !wr_dec && dec_val != '0) |=> (dec_val == $past(dec_val) - HALF_W'(1)));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_tick && !wr_dec && dec_val == '0) |=> (dec_val == '1 && dec_irq));

  p_neg_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dec && wdata_msb && !dec_val[HALF_W-1]) |=> dec_irq);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_irq && !dec_irq_ack) |=> dec_irq);

  p_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write) |=> rd_valid);

  p_no_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && !cmd_write) |=> !rd_valid);
endmodule

bind timebase_dec timebase_dec_chk #(.HALF_W(HALF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tb_tick     (tb_tick),
  .tb_run      (tb_run),
  .dec_tick    (dec_tick),
  .cmd_valid   (cmd_valid),
  .cmd_write   (cmd_write),
  .cmd_addr    (cmd_addr),
  .wdata_msb   (cmd_wdata[HALF_W-1]),
  .rd_valid    (rd_valid),
  .dec_irq     (dec_irq),
  .dec_irq_ack (dec_irq_ack),
  .tb_val      (tb_val),
  .atb_val     (atb_val),
  .dec_val     (dec_val)
);

// File: tb/test_timebase_dec.sv
`timescale 1ns/1ps
module test_timebase_dec;
  localparam logic [31:0] MASK5 = 32'h3FFF_FF80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tb_tick, tb_run, dec_tick;
  logic        cmd_valid, cmd_write;
  logic        cmd_ready;
  logic [2:0]  cmd_addr;
  logic [31:0] cmd_wdata;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        dec_irq, dec_irq_ack;

  always #2.5 clk = ~clk;

  timebase_dec i_timebase_dec (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .tb_run(tb_run),
    .dec_tick(dec_tick), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dec_irq(dec_irq),
    .dec_irq_ack(dec_irq_ack)
  );

  // Reference model state
  logic [63:0] m_tb, m_atb;
  logic [31:0] m_dec;
  logic        m_irq;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R8";
  bit    done = 0;

  function automatic logic [31:0] mread(logic [2:0] a);
    case (a)
      3'd0: return m_tb[31:0];
      3'd1: return m_tb[63:32];
      3'd2: return m_atb[31:0];
      3'd3: return m_atb[63:32];
      3'd4: return m_dec;
      3'd5: return m_tb[31:0] & MASK5;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // One clock: predict from the inputs now applied, then compare after the edge.
  task automatic step();
    bit          e_rv, w, wtb, watb, wdec, ev;
    logic [31:0] e_rd;
    e_rv = cmd_valid && !cmd_write;
    e_rd = mread(cmd_addr);
    w    = cmd_valid && cmd_write;
    wtb  = w && (cmd_addr == 3'd0 || cmd_addr == 3'd1 || cmd_addr == 3'd5);
    watb = w && (cmd_addr == 3'd2 || cmd_addr == 3'd3);
    wdec = w && (cmd_addr == 3'd4);
    ev   = 0;
    if (w) begin
      case (cmd_addr)
        3'd0: m_tb[31:0]   = cmd_wdata;
        3'd1: m_tb[63:32]  = cmd_wdata;
        3'd2: m_atb[31:0]  = cmd_wdata;
        3'd3: m_atb[63:32] = cmd_wdata;
        3'd4: begin
          if (cmd_wdata[31] && !m_dec[31]) ev = 1;
          m_dec = cmd_wdata;
        end
        3'd5: m_tb[31:0] = (m_tb[31:0] & ~MASK5) | (cmd_wdata & MASK5);
        default: ;
      endcase
    end
    if (tb_tick && tb_run && !wtb)  m_tb  = m_tb + 64'd1;
    if (tb_tick && tb_run && !watb) m_atb = m_atb + 64'd1;
    if (dec_tick && !wdec) begin
      if (m_dec == 32'd0) begin
        m_dec = 32'hFFFF_FFFF;
        ev = 1;
      end else begin
        m_dec = m_dec - 32'd1;
      end
    end
    if (ev) m_irq = 1;
    else if (dec_irq_ack) m_irq = 0;
    @(posedge clk);
    #1;
    check("rd_valid", {31'd0, rd_valid}, {31'd0, e_rv});
    if (e_rv) check("rd_data", rd_data, e_rd);
    check("dec_irq", {31'd0, dec_irq}, {31'd0, m_irq});
  endtask

  task automatic rd(logic [2:0] a);
    cmd_valid = 1; cmd_write = 0; cmd_addr = a;
    step();
    cmd_valid = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    cmd_valid = 1; cmd_write = 1; cmd_addr = a; cmd_wdata = d;
    step();
    cmd_valid = 0; cmd_write = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tb_tick = 0; tb_run = 0; dec_tick = 0;
    cmd_valid = 0; cmd_write = 0; cmd_addr = 0; cmd_wdata = 0; dec_irq_ack = 0;
    m_tb = 0; m_atb = 0; m_dec = 32'hFFFF_FFFF; m_irq = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R8: reset values
    cur_req = "R8";
    check("dec_irq at reset", {31'd0, dec_irq}, 32'd0);
    check("rd_valid at reset", {31'd0, rd_valid}, 32'd0);
    for (int a = 0; a < 6; a++) rd(3'(a));

    // R12: ready and unmapped codes
    cur_req = "R12";
    check("cmd_ready", {31'd0, cmd_ready}, 32'd1);
    wr(3'd6, 32'hDEAD_BEEF);
    wr(3'd7, 32'h1234_5678);
    for (int a = 0; a < 8; a++) rd(3'(a));

    // R1: counting with carry into the upper half
    cur_req = "R1";
    tb_run = 1;
    wr(3'd0, 32'hFFFF_FFFD);
    tb_tick = 1;
    idle(4);
    rd(3'd0); rd(3'd1);

    // R3: half writes keep the other half
    cur_req = "R3";
    tb_tick = 0;
    wr(3'd1, 32'hAAAA_5555);
    rd(3'd0); rd(3'd1);
    wr(3'd0, 32'h0000_1111);
    rd(3'd1); rd(3'd0);
    wr(3'd3, 32'h0F0F_0F0F);
    wr(3'd2, 32'h7777_0000);
    rd(3'd3); rd(3'd2);

    // R4: alternate base steps alongside, independent writes
    cur_req = "R4";
    tb_tick = 1;
    idle(3);
    rd(3'd2); rd(3'd0); rd(3'd3);

    // R2: freeze and resume
    cur_req = "R2";
    tb_run = 0;
    idle(5);
    rd(3'd0); rd(3'd2);
    tb_run = 1;
    idle(2);
    rd(3'd0); rd(3'd2);

    // R10: write collides with tick
    cur_req = "R10";
    wr(3'd0, 32'h5000_0000);
    rd(3'd0);
    dec_tick = 1;
    wr(3'd4, 32'h0000_0040);
    rd(3'd4);
    dec_tick = 0;

    // R5: decrementer runs with time bases frozen
    cur_req = "R5";
    tb_run = 0;
    dec_tick = 1;
    idle(6);
    rd(3'd4); rd(3'd0);
    dec_tick = 0;

    // R6: wrap through zero
    cur_req = "R6";
    wr(3'd4, 32'd2);
    dec_tick = 1;
    idle(3);
    rd(3'd4);
    dec_tick = 0;
    rd(3'd4);

    // R11: sticky until acknowledged, event beats ack
    cur_req = "R11";
    idle(3);
    dec_irq_ack = 1;
    step();
    dec_irq_ack = 0;
    idle(2);
    wr(3'd4, 32'd0);
    dec_tick = 1;
    dec_irq_ack = 1;
    step();
    dec_tick = 0;
    dec_irq_ack = 0;
    idle(2);
    dec_irq_ack = 1;
    step();
    dec_irq_ack = 0;

    // R7: negative load over positive raises; over negative does not
    cur_req = "R7";
    wr(3'd4, 32'h0000_0100);
    wr(3'd4, 32'h8000_0000);
    idle(1);
    dec_irq_ack = 1;
    step();
    dec_irq_ack = 0;
    wr(3'd4, 32'h8000_0001);
    idle(2);
    wr(3'd4, 32'h7FFF_FFFF);
    idle(1);
    rd(3'd4);

    // R9: masked view of the main lower half
    cur_req = "R9";
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd5);
    wr(3'd5, 32'h0000_0000);
    rd(3'd0); rd(3'd5);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd0); rd(3'd1);

    // R12: random mix over all codes and strobes
    cur_req = "R12";
    for (int i = 0; i < 600; i++) begin
      cmd_valid   = ($urandom % 3) != 0;
      cmd_write   = ($urandom % 3) == 0;
      cmd_addr    = 3'($urandom % 8);
      cmd_wdata   = ($urandom % 2) ? $urandom : ($urandom % 5);
      tb_tick     = ($urandom % 2) != 0;
      tb_run      = ($urandom % 4) != 0;
      dec_tick    = ($urandom % 2) != 0;
      dec_irq_ack = ($urandom % 6) == 0;
      step();
    end
    cmd_valid = 0; cmd_write = 0; dec_irq_ack = 0;
    for (int a = 0; a < 8; a++) rd(3'(a));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule